// File: doc/BRIEF.md
# Display Control Register Decoder

This block sits on the control side of a display engine. A 32-bit word written to its control port carries a command in its top byte and arguments in the lower 24 bits. From these writes the block keeps a status word, the display start position, the horizontal and vertical display ranges and the video mode. From that state it derives the horizontal and vertical resolution and the visible width and height of the picture.

A second write port receives the drawing-settings words produced by the command path. The decoder keeps a copy of them so that information queries on the control port can return masked views of those settings through a read-back register. Reset commands produce a one-cycle pulse toward the command path, which then drops its queued words and any image transfer in flight.

The visible width is a scaled quotient: the horizontal range, measured in units of 2560 per full line, is multiplied by the resolution and divided by 2560. A small sequential divider does this work and raises a busy flag while it runs.

Top module: `disp_ctrl_decoder`

## Requirements
- R1: Command 0x00 (full reset) sets the status word to 0x14802000, clears the read-back register, returns the eight settings slots to the value (0xE0+slot)<<24, clears display start and both ranges, gives 256x240 resolution with visible width 256 and height 240, and pulses `cmd_path_rst`.
- R2: Command 0x01 raises `cmd_path_rst` for exactly one cycle after the write and changes no other output.
- R3: Command 0x03 copies data bit 0 into status bit 23 (blanking); command 0x04 copies data bits 1:0 into status bits 30:29 (transfer direction).
- R4: Command 0x05 sets `disp_x` from data bits 9:0 and `disp_y` from data bits 18:10.
- R5: Command 0x08 clears status bits 22:16, then places data bits 5:0 in status bits 22:17 and data bit 6 in status bit 16; `hres` follows status bits 18:16 through {256,368,320,384,512,512,640,640} and `vres` follows status bits 20:19 through {240,480,256,480}.
- R6: Command 0x06 sets range start X1 from bits 11:0 and end X2 from bits 23:12; the visible width becomes floor((X2−X1)×hres/2560), or hres itself when X2−X1 is zero, negative or at least 2560. Commands 0x06 and 0x08 both trigger this computation.
- R7: Command 0x07 sets Y1 from bits 9:0 and Y2 from bits 19:10; the visible height is Y2−Y1, doubled when status bit 19 is set, and replaced by vres when that value is zero, negative or above vres. The height is valid in the cycle after the write.
- R8: When the quotient must be computed, `width_busy` is high from the second cycle after the write until the eleventh, `vis_width` holds its old value meanwhile, and the new width appears as `width_busy` falls; in the full-width case the width is taken in the second cycle with no busy period.
- R9: Commands 0x10 to 0x1F are queries selected by data bits 3:0: selectors 2, 3 and 4 load the read-back register with the matching settings slot ANDed with 0x000FFFFF, selectors 5 and 6 with slot 5 ANDed with 0x003FFFFF, selector 7 with 2, and any other selector with 0.
- R10: A settings-port word whose top byte is 0xE0 to 0xE7 is stored whole in the slot given by its top byte's low three bits; settings words with any other top byte are dropped.
- R11: Commands 0x02, 0x09 to 0x0F and 0x20 to 0xFF leave the status word, display start, read-back register, width, height and busy flag unchanged and raise no reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word valid this cycle |
| ctl_wr_data | input | 32 | Control word: command in 31:24, arguments below |
| set_wr_en | input | 1 | Drawing-settings word valid this cycle |
| set_wr_data | input | 32 | Drawing-settings word |
| status_word | output | 32 | Status register |
| disp_x | output | 10 | Display start column |
| disp_y | output | 9 | Display start line |
| hres | output | 10 | Horizontal resolution |
| vres | output | 10 | Vertical resolution |
| vis_width | output | 10 | Visible width |
| vis_height | output | 10 | Visible height |
| width_busy | output | 1 | Width quotient in progress |
| readback | output | 32 | Query read-back register |
| cmd_path_rst | output | 1 | One-cycle reset pulse toward the command path |

## Verification
Status, display start, read-back, resolution, height and the reset pulse are all due in the cycle right after the write edge, so the bench samples them at the falling edge that follows the write. The width has two schedules: in the full-width case it is due one cycle later than the other results, while a real quotient takes eleven cycles, so the bench checks busy one cycle after the write, checks busy together with the old width at ten cycles, and checks the new width with busy low at eleven. Ignored commands are checked at the falling edge right after the write and again one cycle later, so a stray reset pulse or a divider start would be seen.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

   typedef enum logic [7:0] {
      CMD_FULL_RST = 8'h00,
      CMD_PATH_RST = 8'h01,
      CMD_BLANK    = 8'h03,
      CMD_XFER_DIR = 8'h04,
      CMD_START    = 8'h05,
      CMD_HRANGE   = 8'h06,
      CMD_VRANGE   = 8'h07,
      CMD_MODE     = 8'h08
   } ctl_cmd_e;

   localparam logic [31:0] STATUS_RST_VAL = 32'h1480_2000;

   function automatic logic [9:0] hres_of(input logic [2:0] idx);
      case (idx)
         3'd0:    hres_of = 10'd256;
         3'd1:    hres_of = 10'd368;
         3'd2:    hres_of = 10'd320;
         3'd3:    hres_of = 10'd384;
         3'd4,
         3'd5:    hres_of = 10'd512;
         default: hres_of = 10'd640;
      endcase
   endfunction

   function automatic logic [9:0] vres_of(input logic [1:0] idx);
      case (idx)
         2'd0:    vres_of = 10'd240;
         2'd2:    vres_of = 10'd256;
         default: vres_of = 10'd480;
      endcase
   endfunction

endpackage

// File: rtl/dcd_ctrl_regs.sv
module dcd_ctrl_regs
   import dcd_pkg::*;
#(
   parameter int XR_W = 12,
   parameter int YR_W = 10,
   parameter int SX_W = 10,
   parameter int SY_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [31:0]     wr_data,
   output logic [31:0]     status,
   output logic [SX_W-1:0] start_x,
   output logic [SY_W-1:0] start_y,
   output logic [XR_W-1:0] x1,
   output logic [XR_W-1:0] x2,
   output logic [YR_W-1:0] y1,
   output logic [YR_W-1:0] y2,
   output logic            full_rst,
   output logic            query_en,
   output logic            recalc,
   output logic            path_rst
);

   localparam int SY_LSB = 10;

   if (2 * XR_W > 24) begin : g_xr_chk
      $error("horizontal range fields exceed the argument bits");
   end
   if (2 * YR_W > 24 || SY_LSB + SY_W > 24 || SX_W > SY_LSB) begin : g_yr_chk
      $error("vertical or start fields exceed the argument bits");
   end

   logic [7:0] cmd;
   assign cmd      = wr_data[31:24];
   assign full_rst = wr_en && (cmd == CMD_FULL_RST);
   assign query_en = wr_en && (cmd[7:4] == 4'h1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status   <= STATUS_RST_VAL;
         start_x  <= '0;
         start_y  <= '0;
         x1       <= '0;
         x2       <= '0;
         y1       <= '0;
         y2       <= '0;
         recalc   <= 1'b0;
         path_rst <= 1'b0;
      end else begin
         recalc   <= 1'b0;
         path_rst <= 1'b0;
         if (wr_en) begin
            case (cmd)
               CMD_FULL_RST: begin
                  status   <= STATUS_RST_VAL;
                  start_x  <= '0;
                  start_y  <= '0;
                  x1       <= '0;
                  x2       <= '0;
                  y1       <= '0;
                  y2       <= '0;
                  path_rst <= 1'b1;
               end
               CMD_PATH_RST: path_rst <= 1'b1;
               CMD_BLANK:    status[23] <= wr_data[0];
               CMD_XFER_DIR: status[30:29] <= wr_data[1:0];
               CMD_START: begin
                  start_x <= wr_data[SX_W-1:0];
                  start_y <= wr_data[SY_LSB +: SY_W];
               end
               CMD_HRANGE: begin
                  x1     <= wr_data[XR_W-1:0];
                  x2     <= wr_data[XR_W +: XR_W];
                  recalc <= 1'b1;
               end
               CMD_VRANGE: begin
                  y1 <= wr_data[YR_W-1:0];
                  y2 <= wr_data[YR_W +: YR_W];
               end
               CMD_MODE: begin
                  status[22:16] <= {wr_data[5:0], wr_data[6]};
                  recalc        <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dcd_size_calc.sv
module dcd_size_calc
   import dcd_pkg::*;
#(
   parameter int YR_W = 10,
   parameter int HR_W = 10
) (
   input  logic [4:0]      mode,
   input  logic [YR_W-1:0] y1,
   input  logic [YR_W-1:0] y2,
   output logic [HR_W-1:0] hres,
   output logic [HR_W-1:0] vres,
   output logic [HR_W-1:0] height
);

   localparam int DW = YR_W + 2;

   if (HR_W < 10 || DW <= HR_W) begin : g_w_chk
      $error("resolution width must hold 640 and be narrower than the height difference");
   end

   logic signed [DW-1:0] dy;
   logic signed [DW-1:0] dy_sc;
   logic signed [DW-1:0] vres_s;

   assign hres   = HR_W'(hres_of(mode[2:0]));
   assign vres   = HR_W'(vres_of(mode[4:3]));
   assign vres_s = $signed({{(DW-HR_W){1'b0}}, vres});
   assign dy     = $signed({2'b00, y2}) - $signed({2'b00, y1});
   assign dy_sc  = mode[3] ? (dy <<< 1) : dy;

   always_comb begin
      if (dy_sc[DW-1] || dy_sc == '0 || dy_sc > vres_s)
         height = vres;
      else
         height = dy_sc[HR_W-1:0];
   end

endmodule

// File: rtl/dcd_width_div.sv
module dcd_width_div #(
   parameter int XR_W      = 12,
   parameter int HR_W      = 10,
   parameter int SPAN      = 2560,
   parameter int QW        = 10,
   parameter int RST_WIDTH = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            start,
   input  logic [XR_W-1:0] x1,
   input  logic [XR_W-1:0] x2,
   input  logic [HR_W-1:0] hres_in,
   output logic [HR_W-1:0] width,
   output logic            busy
);

   localparam int PW   = XR_W + HR_W;
   localparam int WIDE = PW + QW;
   localparam int KW   = (QW > 1) ? $clog2(QW) : 1;
   localparam logic signed [XR_W:0] SPAN_S = (XR_W+1)'(SPAN);

   if (SPAN >= (1 << XR_W) || SPAN < 1) begin : g_span_chk
      $error("span must be positive and fit the range field");
   end
   if (QW > HR_W) begin : g_q_chk
      $error("quotient must fit the width output");
   end

   logic signed [XR_W:0] diff;
   logic                 full;
   logic [PW-1:0]        prod;
   logic [WIDE-1:0]      rem_q, rem_nx, dsh;
   logic [QW-1:0]        q_q, q_nx;
   logic [KW-1:0]        k_q;
   logic                 take;

   assign diff = $signed({1'b0, x2}) - $signed({1'b0, x1});
   assign full = diff[XR_W] || (diff == '0) || (diff >= SPAN_S);
   assign prod = PW'(diff[XR_W-1:0]) * PW'(hres_in);

   always_comb begin
      dsh    = WIDE'(SPAN) << k_q;
      take   = (rem_q >= dsh);
      rem_nx = take ? (rem_q - dsh) : rem_q;
      q_nx   = take ? (q_q | (QW'(1) << k_q)) : q_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width <= HR_W'(RST_WIDTH);
         busy  <= 1'b0;
         rem_q <= '0;
         q_q   <= '0;
         k_q   <= '0;
      end else if (clear) begin
         width <= HR_W'(RST_WIDTH);
         busy  <= 1'b0;
      end else if (start) begin
         if (full) begin
            width <= hres_in;
            busy  <= 1'b0;
         end else begin
            rem_q <= WIDE'(prod);
            q_q   <= '0;
            k_q   <= KW'(QW - 1);
            busy  <= 1'b1;
         end
      end else if (busy) begin
         rem_q <= rem_nx;
         q_q   <= q_nx;
         if (k_q == '0) begin
            width <= HR_W'(q_nx);
            busy  <= 1'b0;
         end else begin
            k_q <= k_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/dcd_info_query.sv
module dcd_info_query #(
   parameter int SLOTS = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        query_en,
   input  logic [3:0]  sel,
   input  logic        set_wr_en,
   input  logic [31:0] set_wr_data,
   output logic [31:0] readback
);

   localparam int SW = $clog2(SLOTS);
   localparam logic [8:0] BASE = 9'h0E0;
   localparam logic [8:0] TOP  = BASE + 9'(SLOTS);

   if (SLOTS != 8) begin : g_slot_chk
      $error("settings store expects eight slots");
   end

   logic [31:0] slot_q [SLOTS];
   logic        hit;

   assign hit = set_wr_en && ({1'b0, set_wr_data[31:24]} >= BASE)
                          && ({1'b0, set_wr_data[31:24]} < TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
         if (!rst_n || clear)
            slot_q[i] <= {8'(224 + i), 24'h0};
         else if (hit && set_wr_data[24 +: SW] == SW'(i))
            slot_q[i] <= set_wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         readback <= '0;
      end else if (clear) begin
         readback <= '0;
      end else if (query_en) begin
         case (sel)
            4'd2:       readback <= {12'h0, slot_q[2][19:0]};
            4'd3:       readback <= {12'h0, slot_q[3][19:0]};
            4'd4:       readback <= {12'h0, slot_q[4][19:0]};
            4'd5, 4'd6: readback <= {10'h0, slot_q[5][21:0]};
            4'd7:       readback <= 32'd2;
            default:    readback <= '0;
         endcase
      end
   end

   logic unused_slot_bits;
   assign unused_slot_bits = ^{slot_q[0], slot_q[1], slot_q[6], slot_q[7],
                               slot_q[2][31:20], slot_q[3][31:20],
                               slot_q[4][31:20], slot_q[5][31:22]};

endmodule

// File: rtl/disp_ctrl_decoder.sv
module disp_ctrl_decoder #(
   parameter int XR_W      = 12,
   parameter int YR_W      = 10,
   parameter int SX_W      = 10,
   parameter int SY_W      = 9,
   parameter int HR_W      = 10,
   parameter int SPAN      = 2560,
   parameter int QW        = 10,
   parameter int SLOTS     = 8,
   parameter int RST_WIDTH = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_wr_en,
   input  logic [31:0]     ctl_wr_data,
   input  logic            set_wr_en,
   input  logic [31:0]     set_wr_data,
   output logic [31:0]     status_word,
   output logic [SX_W-1:0] disp_x,
   output logic [SY_W-1:0] disp_y,
   output logic [HR_W-1:0] hres,
   output logic [HR_W-1:0] vres,
   output logic [HR_W-1:0] vis_width,
   output logic [HR_W-1:0] vis_height,
   output logic            width_busy,
   output logic [31:0]     readback,
   output logic            cmd_path_rst
);

   logic [XR_W-1:0] x1, x2;
   logic [YR_W-1:0] y1, y2;
   logic            full_rst, query_en, recalc;

   dcd_ctrl_regs #(
      .XR_W(XR_W), .YR_W(YR_W), .SX_W(SX_W), .SY_W(SY_W)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctl_wr_en),
      .wr_data  (ctl_wr_data),
      .status   (status_word),
      .start_x  (disp_x),
      .start_y  (disp_y),
      .x1       (x1),
      .x2       (x2),
      .y1       (y1),
      .y2       (y2),
      .full_rst (full_rst),
      .query_en (query_en),
      .recalc   (recalc),
      .path_rst (cmd_path_rst)
   );

   dcd_size_calc #(
      .YR_W(YR_W), .HR_W(HR_W)
   ) i_size (
      .mode   (status_word[20:16]),
      .y1     (y1),
      .y2     (y2),
      .hres   (hres),
      .vres   (vres),
      .height (vis_height)
   );

   dcd_width_div #(
      .XR_W(XR_W), .HR_W(HR_W), .SPAN(SPAN), .QW(QW), .RST_WIDTH(RST_WIDTH)
   ) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (full_rst),
      .start   (recalc),
      .x1      (x1),
      .x2      (x2),
      .hres_in (hres),
      .width   (vis_width),
      .busy    (width_busy)
   );

   dcd_info_query #(
      .SLOTS(SLOTS)
   ) i_info (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (full_rst),
      .query_en    (query_en),
      .sel         (ctl_wr_data[3:0]),
      .set_wr_en   (set_wr_en),
      .set_wr_data (set_wr_data),
      .readback    (readback)
   );

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
   parameter int HR_W = 10
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ctl_wr_en,
   input logic [31:0]     ctl_wr_data,
   input logic [31:0]     status_word,
   input logic [31:0]     readback,
   input logic [HR_W-1:0] vres,
   input logic [HR_W-1:0] vis_width,
   input logic [HR_W-1:0] vis_height,
   input logic            width_busy,
   input logic            cmd_path_rst
);

   logic [7:0] cmd;
   logic       ign;
   assign cmd = ctl_wr_data[31:24];
   assign ign = (cmd == 8'h02) || (cmd >= 8'h09 && cmd <= 8'h0F) || (cmd > 8'h1F);

   AST_FULL_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_en && cmd == 8'h00 |=> status_word == 32'h1480_2000 && readback == '0 && cmd_path_rst); // R1

   AST_PATH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_en && cmd == 8'h01 |=> cmd_path_rst); // R2

   AST_BLANK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_en && cmd == 8'h03 |=> status_word[23] == $past(ctl_wr_data[0])); // R3

   AST_HEIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      vis_height != '0 && vis_height <= vres); // R7

   AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      width_busy && $past(width_busy) |-> $stable(vis_width)); // R8

   AST_QUERY_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_en && cmd[7:4] == 4'h1 && ctl_wr_data[3:0] == 4'd7 |=> readback == 32'd2); // R9

   AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_en && ign |=> $stable(status_word) && $stable(readback) && !cmd_path_rst); // R11

endmodule

bind disp_ctrl_decoder dcd_checker #(.HR_W(HR_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_wr_en    (ctl_wr_en),
   .ctl_wr_data  (ctl_wr_data),
   .status_word  (status_word),
   .readback     (readback),
   .vres         (vres),
   .vis_width    (vis_width),
   .vis_height   (vis_height),
   .width_busy   (width_busy),
   .cmd_path_rst (cmd_path_rst)
);

// File: tb/test_disp_ctrl_decoder.sv
module test_disp_ctrl_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr_en = 1'b0;
   logic [31:0] ctl_wr_data = '0;
   logic        set_wr_en = 1'b0;
   logic [31:0] set_wr_data = '0;
   logic [31:0] status_word, readback;
   logic [9:0]  disp_x, hres, vres, vis_width, vis_height;
   logic [8:0]  disp_y;
   logic        width_busy, cmd_path_rst;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_status;
   int bx1, bx2, by1, by2, bdx, bdy, cur_w;

   always #5 clk = ~clk;

   disp_ctrl_decoder i_disp_ctrl_decoder (
      .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
      .set_wr_en(set_wr_en), .set_wr_data(set_wr_data), .status_word(status_word),
      .disp_x(disp_x), .disp_y(disp_y), .hres(hres), .vres(vres),
      .vis_width(vis_width), .vis_height(vis_height), .width_busy(width_busy),
      .readback(readback), .cmd_path_rst(cmd_path_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] w);
      @(negedge clk);
      ctl_wr_en = 1'b1; ctl_wr_data = w;
      @(negedge clk);
      ctl_wr_en = 1'b0; ctl_wr_data = '0;
   endtask

   task automatic sw(input logic [31:0] w);
      @(negedge clk);
      set_wr_en = 1'b1; set_wr_data = w;
      @(negedge clk);
      set_wr_en = 1'b0; set_wr_data = '0;
   endtask

   function automatic int ex_hres(input logic [31:0] s);
      case (s[18:16])
         3'd0: return 256; 3'd1: return 368; 3'd2: return 320; 3'd3: return 384;
         3'd4, 3'd5: return 512;
         default: return 640;
      endcase
   endfunction

   function automatic int ex_vres(input logic [31:0] s);
      case (s[20:19])
         2'd0: return 240; 2'd2: return 256;
         default: return 480;
      endcase
   endfunction

   function automatic int ex_height(input logic [31:0] s);
      int d = by2 - by1;
      if (s[19]) d = d * 2;
      if (d <= 0 || d > ex_vres(s)) return ex_vres(s);
      return d;
   endfunction

   // R6 / R8: follow the width computation on its schedule
   task automatic follow_width(input string req);
      int d = bx2 - bx1;
      int h = ex_hres(exp_status);
      int e;
      if (d <= 0 || d >= 2560) begin
         step(1);
         chk({req, " R8 busy stays low"}, 32'(width_busy), 32'd0);
         chk({req, " R6 full width"}, 32'(vis_width), 32'(h));
         cur_w = h;
      end else begin
         e = d * h / 2560;
         step(1);
         chk({req, " R8 busy rises"}, 32'(width_busy), 32'd1);
         step(9);
         chk({req, " R8 busy held"}, 32'(width_busy), 32'd1);
         chk({req, " R8 width held"}, 32'(vis_width), 32'(cur_w));
         step(1);
         chk({req, " R8 busy falls"}, 32'(width_busy), 32'd0);
         chk({req, " R6 quotient"}, 32'(vis_width), 32'(e));
         cur_w = e;
      end
   endtask

   task automatic mode(input logic [6:0] d);
      exp_status = (exp_status & ~32'h007F_0000) | (32'(d[5:0]) << 17) | (32'(d[6]) << 16);
      wr(32'h0800_0000 | 32'(d));
      chk("R5 status", status_word, exp_status);
      chk("R5 hres", 32'(hres), 32'(ex_hres(exp_status)));
      chk("R5 vres", 32'(vres), 32'(ex_vres(exp_status)));
      follow_width("R5");
   endtask

   task automatic t_reset_state;
      chk("R1 status after reset", status_word, 32'h1480_2000);
      chk("R1 hres", 32'(hres), 32'd256);
      chk("R1 vres", 32'(vres), 32'd240);
      chk("R1 width", 32'(vis_width), 32'd256);
      chk("R1 height", 32'(vis_height), 32'd240);
      chk("R1 readback", readback, 32'd0);
      chk("R1 no pulse", 32'(cmd_path_rst), 32'd0);
   endtask

   task automatic t_path_reset;
      wr(32'h0100_0000);
      chk("R2 pulse high", 32'(cmd_path_rst), 32'd1);
      chk("R2 status kept", status_word, exp_status);
      step(1);
      chk("R2 pulse one cycle", 32'(cmd_path_rst), 32'd0);
   endtask

   task automatic t_blank_dir;
      wr(32'h0300_0000);
      exp_status[23] = 1'b0;
      chk("R3 blank clear", status_word, exp_status);
      wr(32'h0400_0002);
      exp_status[30:29] = 2'd2;
      chk("R3 direction", status_word, exp_status);
      wr(32'h0300_0001);
      exp_status[23] = 1'b1;
      chk("R3 blank set", status_word, exp_status);
   endtask

   task automatic t_start;
      wr(32'h0507_FFFF);
      chk("R4 start x max", 32'(disp_x), 32'h3FF);
      chk("R4 start y max", 32'(disp_y), 32'h1FF);
      wr(32'h0500_1C05);
      bdx = 5; bdy = 7;
      chk("R4 start x", 32'(disp_x), 32'(bdx));
      chk("R4 start y", 32'(disp_y), 32'(bdy));
   endtask

   task automatic t_width;
      bx1 = 500; bx2 = 2000;
      wr(32'h067D_01F4);
      follow_width("R6 range 500..2000");
      mode(7'h01);
      mode(7'h40);
      mode(7'h04);
   endtask

   task automatic t_width_full;
      bx1 = 100; bx2 = 50;
      wr(32'h0603_2064);
      follow_width("R6 reversed range");
      mode(7'h06);
      bx1 = 'h260; bx2 = 'hC60;
      wr(32'h06C6_0260);
      follow_width("R6 span 2560");
   endtask

   task automatic t_height;
      mode(7'h00);
      by1 = 16; by2 = 256;
      wr(32'h0704_0010);
      chk("R7 height equal vres", 32'(vis_height), 32'(ex_height(exp_status)));
      by2 = 200;
      wr(32'h0703_2010);
      chk("R7 height 184", 32'(vis_height), 32'(ex_height(exp_status)));
      mode(7'h04);
      chk("R7 doubled", 32'(vis_height), 32'(ex_height(exp_status)));
      by1 = 0; by2 = 300;
      wr(32'h0704_B000);
      chk("R7 clamp above vres", 32'(vis_height), 32'(ex_height(exp_status)));
      by1 = 300; by2 = 10;
      wr(32'h0700_292C);
      chk("R7 negative gives vres", 32'(vis_height), 32'(ex_height(exp_status)));
      mode(7'h00);
      chk("R7 single height vres", 32'(vis_height), 32'(ex_height(exp_status)));
   endtask

   task automatic t_query;
      sw(32'hE2AB_CDEF);
      wr(32'h1000_0002);
      chk("R9 sel2", readback, 32'h000B_CDEF);
      sw(32'hE5FF_FFFF);
      wr(32'h1F00_0005);
      chk("R9 sel5", readback, 32'h003F_FFFF);
      wr(32'h1000_0009);
      chk("R9 other sel", readback, 32'd0);
      wr(32'h1000_0006);
      chk("R9 sel6", readback, 32'h003F_FFFF);
      wr(32'h1000_0007);
      chk("R9 sel7", readback, 32'd2);
      sw(32'hE301_2345);
      wr(32'h1000_0003);
      chk("R10 slot3 stored", readback, 32'h0001_2345);
      sw(32'hD400_0001);
      wr(32'h1000_0004);
      chk("R10 foreign word dropped", readback, 32'd0);
   endtask

   task automatic t_ignored;
      logic [31:0] words [5];
      logic [31:0] rb;
      words[0] = 32'h02FF_FFFF; words[1] = 32'h09FF_FFFF; words[2] = 32'h0FFF_FFFF;
      words[3] = 32'h20FF_FFFF; words[4] = 32'hFF00_0001;
      rb = readback;
      for (int i = 0; i < 5; i++) begin
         wr(words[i]);
         chk("R11 status", status_word, exp_status);
         chk("R11 readback", readback, rb);
         chk("R11 start", {22'h0, disp_x}, 32'(bdx));
         chk("R11 height", 32'(vis_height), 32'(ex_height(exp_status)));
         chk("R11 no pulse", 32'(cmd_path_rst), 32'd0);
         step(1);
         chk("R11 no busy", 32'(width_busy), 32'd0);
         chk("R11 width", 32'(vis_width), 32'(cur_w));
      end
   endtask

   task automatic t_full_reset;
      sw(32'hE4FF_FFFF);
      wr(32'h1000_0004);
      chk("R9 sel4", readback, 32'h000F_FFFF);
      wr(32'h0000_0000);
      chk("R1 status", status_word, 32'h1480_2000);
      chk("R1 readback cleared", readback, 32'd0);
      chk("R1 pulse", 32'(cmd_path_rst), 32'd1);
      chk("R1 start cleared", {13'h0, disp_y, disp_x}, 32'd0);
      chk("R1 hres", 32'(hres), 32'd256);
      chk("R1 vres", 32'(vres), 32'd240);
      chk("R1 width", 32'(vis_width), 32'd256);
      chk("R1 height", 32'(vis_height), 32'd240);
      wr(32'h1000_0004);
      chk("R1 slot4 reset", readback, 32'd0);
   endtask

   initial begin
      exp_status = 32'h1480_2000;
      bx1 = 0; bx2 = 0; by1 = 0; by2 = 0; bdx = 0; bdy = 0; cur_w = 256;
      step(3);
      rst_n = 1'b1;
      step(2);
      t_reset_state();
      t_path_reset();
      t_blank_dir();
      t_start();
      t_width();
      t_width_full();
      t_height();
      t_query();
      t_ignored();
      t_full_reset();
      step(2);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule